// File: doc/BRIEF.md
# GCD Loop Dependence Tester

This unit decides whether a store to array element X[a*i+b] and a load from X[c*i+d], both indexed by the same loop variable, could ever touch the same element. It accepts four signed 16-bit coefficients with a start pulse. It forms the greatest common divisor of |a| and |c| by repeated subtraction, one step per clock. It then tests whether that divisor divides |d-b|, again by repeated subtraction. When it has finished, it raises a one-cycle done pulse and a registered may-depend flag.

If the divisor does not divide the index difference, the two accesses can never alias, and reordering them is safe. A passing test gives no proof of a dependence. The loop bounds are never considered, so the integer solution may lie outside the iteration range. The flag is therefore conservative: a 1 means "may depend" and a 0 means "independent". The unit serves as a sequential helper next to a scheduler or an analysis engine that has already extracted the affine coefficients.

Top module: `gcd_dep_tester`

## Requirements
- R1: After reset, busy, done and mayDepend are all 0.
- R2: A start seen while busy is 0 is accepted, and busy reads 1 from the next clock until the operation finishes.
- R3: Completion is marked by done high for exactly one cycle, with busy already 0 in that cycle. mayDepend changes only on completion and holds its value until the next completion.
- R4: With g = gcd(|a|,|c|) nonzero, mayDepend is 1 exactly when g divides |d-b|. For example, a=2, b=3, c=2, d=0 gives g=2 and a difference of -3, so mayDepend is 0.
- R5: When a and c are both zero, mayDepend is 1 exactly when b equals d.
- R6: When d equals b, mayDepend is 1 whatever a and c are.
- R7: A start raised while busy is 1 is ignored. It produces no extra done pulse, and the pending result belongs to the accepted operands.
- R8: Coefficient signs do not affect the answer, because magnitudes of a, c and d-b are used. This holds for the extreme value -32768 as well, and for a single zero coefficient, where the divisor is the magnitude of the other coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a test with the present coefficients |
| coefA | input | 16 | Signed store stride a |
| coefB | input | 16 | Signed store offset b |
| coefC | input | 16 | Signed load stride c |
| coefD | input | 16 | Signed load offset d |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| mayDepend | output | 1 | 1 = a dependence is possible, 0 = the accesses are independent |

## Verification
The coefficient sets cover three kinds of case. In divisible and non-divisible pairs with a nontrivial divisor, a wrong gcd or a wrong remainder changes the flag. Mixed-sign and extreme-value operands, including -32768 and a 65535-wide difference, separate correct magnitude handling from plain two's-complement arithmetic. Degenerate operands cover a zero difference, both strides zero, and one stride zero, and these exercise the early-exit paths. A start pulsed in the middle of a long computation, with operands that would give the opposite answer, shows whether the busy interlock holds.

// File: rtl/gcd_dep_pkg.sv
package gcd_dep_pkg;
  typedef struct packed {
    logic load;     // capture operand magnitudes
    logic gcdStep;  // one subtraction of the gcd loop
    logic divStep;  // one subtraction of the divisibility loop
    logic finish;   // latch the verdict
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GCD  = 2'd1,
    ST_DIV  = 2'd2
  } phase_t;
endpackage

// File: rtl/gcd_dep_datapath.sv
module gcd_dep_datapath
  import gcd_dep_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic signed [W-1:0] coefA,
  input  logic signed [W-1:0] coefB,
  input  logic signed [W-1:0] coefC,
  input  logic signed [W-1:0] coefD,
  output logic                gcdDone,
  output logic                divDone,
  output logic                mayDepend
);
  localparam int DW = W + 1;

  logic [W-1:0]         opX, opY;
  logic [DW-1:0]        remR;
  logic                 depR;
  logic [DW-1:0]        gVal;
  logic signed [DW-1:0] diffS;
  logic [W-1:0]         magA, magC;
  logic [DW-1:0]        magDiff;

  // magnitudes; the most negative value maps onto its unsigned magnitude
  always_comb begin
    magA    = coefA[W-1] ? (~coefA + 1'b1) : coefA;
    magC    = coefC[W-1] ? (~coefC + 1'b1) : coefC;
    diffS   = {coefD[W-1], coefD} - {coefB[W-1], coefB};
    magDiff = diffS[DW-1] ? (~diffS + 1'b1) : diffS;
  end

  // once one operand is zero the other holds the gcd
  assign gVal    = {1'b0, opX | opY};
  assign gcdDone = (opX == '0) || (opY == '0);
  assign divDone = (gVal == '0) || (remR < gVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opX  <= '0;
      opY  <= '0;
      remR <= '0;
      depR <= 1'b0;
    end else begin
      if (strobes.load) begin
        opX  <= magA;
        opY  <= magC;
        remR <= magDiff;
      end
      if (strobes.gcdStep) begin
        if (opX >= opY) opX <= opX - opY;
        else            opY <= opY - opX;
      end
      if (strobes.divStep) remR <= remR - gVal;
      if (strobes.finish)  depR <= (remR == '0);
    end
  end

  assign mayDepend = depR;
endmodule

// File: rtl/gcd_dep_ctrl.sv
module gcd_dep_ctrl
  import gcd_dep_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         gcdDone,
  input  logic         divDone,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  phase_t phase, phaseNext;
  logic   doneR;

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    unique case (phase)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        phaseNext    = ST_GCD;
      end
      ST_GCD: if (gcdDone) phaseNext = ST_DIV;
              else strobes.gcdStep = 1'b1;
      ST_DIV: if (divDone) begin
        strobes.finish = 1'b1;
        phaseNext      = ST_IDLE;
      end else strobes.divStep = 1'b1;
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      doneR <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneR <= strobes.finish;
    end
  end

  assign busy = (phase != ST_IDLE);
  assign done = doneR;
endmodule

// File: rtl/gcd_dep_tester.sv
module gcd_dep_tester
  import gcd_dep_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] coefA,
  input  logic signed [W-1:0] coefB,
  input  logic signed [W-1:0] coefC,
  input  logic signed [W-1:0] coefD,
  output logic                busy,
  output logic                done,
  output logic                mayDepend
);
  ctrlStrobes_t strobes;
  logic         gcdDone, divDone;

  gcd_dep_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .gcdDone(gcdDone), .divDone(divDone),
    .strobes(strobes), .busy(busy), .done(done)
  );

  gcd_dep_datapath #(.W(W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .coefA(coefA), .coefB(coefB), .coefC(coefC), .coefD(coefD),
    .gcdDone(gcdDone), .divDone(divDone), .mayDepend(mayDepend)
  );
endmodule

// File: rtl/gcd_dep_checker.sv
module gcd_dep_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic mayDepend
);
  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(mayDepend));
  // R7
  done_from_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  // R1
  always @(posedge clk) begin
    if (rstN && $past(!rstN)) begin
      reset_state_chk: assert (!busy && !done && !mayDepend);
    end
  end
endmodule

bind gcd_dep_tester gcd_dep_checker uChk (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .mayDepend(mayDepend)
);

// File: tb/sim_gcd_dep_tester.sv
module sim_gcd_dep_tester;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] coefA = '0, coefB = '0, coefC = '0, coefD = '0;
  logic busy, done, mayDepend;

  int nChecks = 0;
  int nFails = 0;
  int nDones = 0;
  int nPushed = 0;

  typedef struct {
    bit    exp;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  gcd_dep_tester u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .coefA(coefA), .coefB(coefB), .coefC(coefC), .coefD(coefD),
    .busy(busy), .done(done), .mayDepend(mayDepend)
  );

  function automatic bit refDep(int a, int b, int c, int d);
    int x, y, t, diff;
    x    = (a < 0) ? -a : a;
    y    = (c < 0) ? -c : c;
    diff = d - b;
    if (diff < 0) diff = -diff;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    if (x == 0) return (diff == 0);
    return (diff % x) == 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops an expected verdict on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        nDones++;
        if (expQ.size() == 0) begin
          check("R7 unexpected done", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.tag, mayDepend, it.exp);
        end
      end
    end
  end

  // driver: one accepted operation, then wait for its completion
  task automatic runOp(int a, int b, int c, int d, string tag);
    expItem_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    coefA = 16'(a); coefB = 16'(b); coefC = 16'(c); coefD = 16'(d);
    start = 1'b1;
    it.exp = refDep(a, b, c, d);
    it.tag = tag;
    expQ.push_back(it);
    nPushed++;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 mayDepend", mayDepend, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", busy, 0);

    // R4: divisibility with a nonzero divisor
    runOp(2, 3, 2, 0, "R4 example 2,3,2,0");
    runOp(4, 1, 6, 7, "R4 gcd2 diff6");
    runOp(9, 0, 6, 4, "R4 gcd3 diff4");
    runOp(12, -3, 18, 27, "R4 gcd6 diff30");
    runOp(35, 0, 21, 13, "R4 gcd7 diff13");
    // R3: done is gone and the flag holds after completion
    @(negedge clk);
    check("R3 done single pulse", done, 0);
    check("R3 flag holds", mayDepend, 0);
    repeat (3) @(negedge clk);
    check("R3 flag still held", mayDepend, 0);
    // R5: both strides zero
    runOp(0, 5, 0, 5, "R5 zero strides equal offsets");
    runOp(0, 5, 0, 6, "R5 zero strides unequal offsets");
    // R6: equal offsets
    runOp(4, 9, 6, 9, "R6 equal offsets");
    runOp(-30000, -7, 29999, -7, "R6 equal offsets large strides");
    // R8: signs, extremes and a single zero stride
    runOp(-4, 1, 6, -1, "R8 mixed signs dep");
    runOp(-6, 0, -9, -4, "R8 negative strides indep");
    runOp(0, 0, -10, 25, "R8 one zero stride");
    runOp(-32768, -32768, 0, 32767, "R8 extreme diff 65535");
    runOp(-32768, 0, 0, -32768, "R8 extreme stride");

    // R7: start while busy must be ignored
    begin
      expItem_t it;
      @(negedge clk);
      coefA = 16'sd30; coefB = 16'sd0; coefC = 16'sd18; coefD = 16'sd12;
      start = 1'b1;
      it.exp = refDep(30, 0, 18, 12);
      it.tag = "R7 first operands kept";
      expQ.push_back(it);
      nPushed++;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R7 busy mid operation", busy, 1);
      coefA = 16'sd2; coefB = 16'sd3; coefC = 16'sd2; coefD = 16'sd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (6) @(negedge clk);
      check("R7 no extra operation", busy, 0);
    end

    check("R7 done count", nDones, nPushed);
    check("R7 queue drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule